// File: doc/BRIEF.md
# Byte-Stream Fetch-Execute Sequencer

This block is a small sequencer that pulls a program from a byte-wide instruction memory, one byte per request. It decodes variable-length instructions and runs them one at a time. Three operations are understood: a halt, a no-operation, and a two-operand 64-bit addition into a file of fifteen general registers. Any other opcode byte is stepped over. The sequencer has a single program counter, and the counter moves forward by one for every byte the core consumes, operand bytes included.

Fetches use a simple request/valid handshake. The core raises `mem_req` with `mem_addr` equal to the program counter. It holds both until the memory answers, either with `mem_rvalid` and a data byte or with `mem_err`. The core stops in three cases: a halt opcode, a fetch error, or an illegal register number inside an addition. Only the two error cases produce a one-cycle `fault` pulse. A `start` pulse resumes a stopped core at the current program counter. A combinational read port shows any register, so the results can be inspected.

Top module: `bytecode_core`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter (seen on `mem_addr`) is 0, every register reads 0, `halted` is 0 and `fault` is 0.
- R2: While running, the core issues one byte request at a time with `mem_addr` equal to the program counter. It holds `mem_req` and `mem_addr` steady until `mem_rvalid` or `mem_err`. Each byte accepted with `mem_rvalid` advances the program counter by exactly one.
- R3: Opcode 0x0E halts the core: `halted` rises the cycle after that byte is accepted, and no further request is issued.
- R4: Opcode 0x00 (no-op), and every opcode other than 0x00, 0x01 and 0x0E, consumes only its own byte, changes no register and does not stop the core.
- R5: Opcode 0x01 (add) is followed by a destination byte and then a first-operand byte. In that byte, bit 0 set means immediate and bit 0 clear means register; bits 7:1 give the first source register. In register form, one more byte names the second source register.
- R6: In immediate form the second operand is the next four bytes, lowest-order byte first, zero-extended to 64 bits.
- R7: The destination receives the 64-bit sum of the two operands, wrapping modulo 2^64. Sources are read before the write, so the destination may also be a source.
- R8: Register numbers 0x00 to 0x0E are legal, and register 0 is not a legal destination. An illegal destination or first source is detected when the first-operand byte is accepted. An illegal second source is detected when its byte is accepted. On detection the core stops with a fault, writes no register, and leaves the program counter just past the offending byte.
- R9: A request answered with `mem_err` stops the core with a fault. The byte is not consumed, so the program counter keeps its address.
- R10: `fault` is high for exactly one cycle on each error stop (R8, R9) and never on a halt opcode.
- R11: `start` while stopped resumes fetching at the unchanged program counter with all registers kept. `start` while running, including the cycle in which a halt byte is accepted, has no effect.
- R12: `rd_data` shows register `rd_sel` in the same cycle. A selector of 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Resume a stopped core |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | AW | Fetch address, always equal to the program counter |
| mem_rvalid | input | 1 | Fetch answered with data |
| mem_rdata | input | 8 | Fetched byte |
| mem_err | input | 1 | Fetch answered with an error |
| halted | output | 1 | Core is stopped |
| fault | output | 1 | One-cycle pulse on an error stop |
| rd_sel | input | RIW | Register read selector |
| rd_data | output | XLEN | Selected register value |

## Verification
The collision of interest is a `start` pulse landing in the very cycle the core accepts a halt byte. The resume logic and the halt logic both act on the run flag in that one cycle, and the halt must win. The memory model in the bench raises `start` together with the `mem_rvalid` that delivers a 0x0E byte. Random pulses of `start` during running are added on top. The bench then judges the outcome at the ports: `halted` stays high, `mem_req` stays low, and `mem_addr` stays one past the halt byte for several cycles. Register contents and fault counts must match a bench-side instruction model.

// File: rtl/bytecode_core.sv
module bytecode_core #(
  parameter int XLEN  = 64,
  parameter int NREGS = 15,
  parameter int AW    = 16,
  localparam int RIW  = $clog2(NREGS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_err,
  output logic            halted,
  output logic            fault,
  input  logic [RIW-1:0]  rd_sel,
  output logic [XLEN-1:0] rd_data
);

  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_ADD = 8'h01;
  localparam logic [7:0] OP_HLT = 8'h0E;
  localparam logic [7:0] NR8    = 8'(NREGS);

  typedef enum logic [2:0] {PH_OPC, PH_DST, PH_OP1, PH_SRC2, PH_IMM, PH_EXEC} phase_t;

  phase_t          ph;
  logic            run;
  logic            fault_q;
  logic [AW-1:0]   pc_q;
  logic [7:0]      dst_q;
  logic [6:0]      s1_q;
  logic [7:0]      s2_q;
  logic            imm_sel;
  logic [31:0]     imm_q;
  logic [1:0]      ibc;
  logic [XLEN-1:0] rf [NREGS];

  assign mem_req  = run && (ph != PH_EXEC);
  assign mem_addr = pc_q;
  assign halted   = !run;
  assign fault    = fault_q;

  wire take = mem_req && mem_rvalid && !mem_err;
  wire ferr = mem_req && mem_err;

  wire op1_bad = (dst_q >= NR8) || (dst_q == 8'd0) || ({1'b0, mem_rdata[7:1]} >= NR8);
  wire src2_bad = mem_rdata >= NR8;

  wire [XLEN-1:0] opnd2 = imm_sel ? XLEN'(imm_q) : rf[s2_q[RIW-1:0]];
  wire [XLEN-1:0] sum   = rf[s1_q[RIW-1:0]] + opnd2;

  assign rd_data = (rd_sel < RIW'(NREGS)) ? rf[rd_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b1;
      ph      <= PH_OPC;
      fault_q <= 1'b0;
      pc_q    <= '0;
      dst_q   <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      imm_sel <= 1'b0;
      imm_q   <= '0;
      ibc     <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      fault_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          ph  <= PH_OPC;
        end
      end else if (ferr) begin
        run     <= 1'b0;
        fault_q <= 1'b1;
      end else if (ph == PH_EXEC) begin
        rf[dst_q[RIW-1:0]] <= sum;
        ph <= PH_OPC;
      end else if (take) begin
        pc_q <= pc_q + 1'b1;
        case (ph)
          PH_OPC: begin
            if (mem_rdata == OP_HLT)      run <= 1'b0;
            else if (mem_rdata == OP_ADD) ph  <= PH_DST;
            else                          ph  <= PH_OPC;
          end
          PH_DST: begin
            dst_q <= mem_rdata;
            ph    <= PH_OP1;
          end
          PH_OP1: begin
            s1_q    <= mem_rdata[7:1];
            imm_sel <= mem_rdata[0];
            ibc     <= '0;
            if (op1_bad) begin
              run     <= 1'b0;
              fault_q <= 1'b1;
              ph      <= PH_OPC;
            end else begin
              ph <= mem_rdata[0] ? PH_IMM : PH_SRC2;
            end
          end
          PH_SRC2: begin
            s2_q <= mem_rdata;
            if (src2_bad) begin
              run     <= 1'b0;
              fault_q <= 1'b1;
              ph      <= PH_OPC;
            end else begin
              ph <= PH_EXEC;
            end
          end
          PH_IMM: begin
            imm_q <= {mem_rdata, imm_q[31:8]};
            ibc   <= ibc + 1'b1;
            if (ibc == 2'd3) ph <= PH_EXEC;
          end
          default: ph <= PH_OPC;
        endcase
      end
    end
  end

  wire unused_ok = ^{OP_NOP};

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !mem_err) |=> (mem_req && $stable(mem_addr)))
    else $error("request dropped or address moved while waiting");

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mem_addr == $past(mem_addr) + 1'b1))
    else $error("program counter did not step by one");

  assert_hlt_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ph == PH_OPC && mem_rdata == OP_HLT) |=> (halted && !fault))
    else $error("halt opcode did not stop the core cleanly");

  assert_err_keeps_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |=> (halted && fault && mem_addr == $past(mem_addr)))
    else $error("fetch error handling wrong");

  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault)
    else $error("fault longer than one cycle");

  assert_stay_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted)
    else $error("core resumed without start");

endmodule

// File: tb/bytecode_core_tb.sv
module bytecode_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_b = 0;
  logic        mstart = 0;
  logic        start;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [7:0]  mem_rdata = 0;
  logic        mem_err = 0;
  logic        halted;
  logic        fault;
  logic [3:0]  rd_sel = 0;
  logic [63:0] rd_data;

  assign start = start_b | mstart;

  always #4 clk = ~clk;

  bytecode_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .halted(halted), .fault(fault), .rd_sel(rd_sel), .rd_data(rd_data));

  logic [7:0]  rom [256];
  logic [63:0] xr [15];
  int          mpc;
  bit          mfault;
  int          err_addr = -1;
  bit          hlt_start = 0;
  bit          poke = 0;
  int          wp;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers each request after 0..2 extra cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid || mem_err || mstart) begin
        mem_rvalid = 0; mem_err = 0; mstart = 0;
      end else if (rst_n && mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (int'(mem_addr) == err_addr) mem_err = 1;
        else begin
          mem_rdata  = rom[mem_addr[7:0]];
          mem_rvalid = 1;
          if (hlt_start && mem_rdata == 8'h0E) mstart = 1;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit mget(input int a, output logic [7:0] b);
    b = rom[a[7:0]];
    return a == err_addr;
  endfunction

  task automatic model_run(input int from);
    int p = from;
    bit stop = 0;
    int g = 0;
    logic [7:0] op, d, o, s, b;
    logic [63:0] v2;
    mfault = 0;
    while (g < 2000) begin
      g++;
      if (mget(p, op)) begin mfault = 1; break; end
      p++;
      if (op == 8'h0E) break;
      if (op != 8'h01) continue;
      if (mget(p, d)) begin mfault = 1; break; end
      p++;
      if (mget(p, o)) begin mfault = 1; break; end
      p++;
      if (d > 14 || d == 0 || o[7:1] > 14) begin mfault = 1; break; end
      v2 = 0;
      if (o[0]) begin
        for (int k = 0; k < 4; k++) begin
          if (mget(p, b)) begin mfault = 1; stop = 1; break; end
          p++;
          v2 |= 64'(b) << (8 * k);
        end
      end else begin
        if (mget(p, s)) begin mfault = 1; stop = 1; end
        else begin
          p++;
          if (s > 14) begin mfault = 1; stop = 1; end
          else v2 = xr[s[3:0]];
        end
      end
      if (stop) break;
      xr[d[3:0]] = xr[o[4:1]] + v2;
    end
    mpc = p;
  endtask

  task automatic emit(input logic [7:0] b);
    rom[wp[7:0]] = b;
    wp++;
  endtask

  task automatic add_imm(input logic [7:0] d, input logic [6:0] s1, input logic [31:0] v);
    emit(8'h01); emit(d); emit({s1, 1'b1});
    for (int k = 0; k < 4; k++) emit(v[8*k +: 8]);
  endtask

  task automatic add_reg(input logic [7:0] d, input logic [6:0] s1, input logic [7:0] s2);
    emit(8'h01); emit(d); emit({s1, 1'b0}); emit(s2);
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h0E;
    wp = 0;
  endtask

  task automatic gen_prog(input int n, input bit allow_bad);
    for (int i = 0; i < n && wp < 230; i++) begin
      int r = $urandom % 10;
      logic [7:0] d = 8'(1 + $urandom % 14);
      logic [6:0] s = 7'($urandom % 15);
      if (r < 5) add_imm(d, s, $urandom);
      else if (r < 8) add_reg(d, s, 8'($urandom % 15));
      else if (r == 8) emit(($urandom % 2) ? 8'h00 : 8'(2 + $urandom % 12));
      else if (allow_bad) begin
        case ($urandom % 4)
          0: add_reg(8'h00, s, 8'h01);
          1: add_imm(8'(15 + $urandom % 200), s, 32'h1);
          2: add_imm(d, 7'(15 + $urandom % 100), 32'h1);
          default: add_reg(d, s, 8'(15 + $urandom % 200));
        endcase
      end else emit(8'h10 + 8'($urandom % 240));
    end
    emit(8'h0E);
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 15; i++) xr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_until_halt(input string req);
    int faults = 0;
    int n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (fault) faults++;
      start_b = poke && !halted && ($urandom % 16 == 0);
      if (halted) begin start_b = 0; break; end
    end
    chk(halted, "R3", 64'(halted), 1);
    chk(int'(mem_addr) == mpc, req, 64'(mem_addr), 64'(mpc));
    chk(faults == int'(mfault), "R10", 64'(faults), 64'(mfault));
    repeat (6) @(negedge clk);
    chk(halted && !mem_req && int'(mem_addr) == mpc, "R11 stays stopped",
        {mem_req, halted, 16'(mem_addr)}, {2'b01, 16'(mpc)});
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 15; i++) begin
      rd_sel = 4'(i);
      #1;
      chk(rd_data === xr[i], req, rd_data, xr[i]);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_b = 1;
    @(negedge clk); start_b = 0;
  endtask

  task automatic run_prog(input string req);
    do_reset();
    model_run(0);
    run_until_halt(req);
    check_regs(req);
  endtask

  initial begin
    // R1: reset state
    clear_rom();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(mem_addr == 0 && !halted && !fault, "R1 during reset", {mem_addr, halted, fault}, 0);
    for (int i = 0; i < 15; i++) xr[i] = 0;
    check_regs("R1 regs zero");
    rst_n = 1;
    #1;
    chk(mem_addr == 0 && !halted && !fault, "R1 after release", {mem_addr, halted, fault}, 0);

    // R5 R6 R4 directed encoding
    clear_rom();
    add_imm(8'd3, 7'd0, 32'h89AB_CDEF);
    add_reg(8'd4, 7'd3, 8'd3);
    emit(8'h00); emit(8'h7F); emit(8'h0F); emit(8'h02);
    add_reg(8'd4, 7'd4, 8'd14);
    emit(8'h0E);
    run_prog("R5 encoding");
    rd_sel = 4'd3; #1;
    chk(rd_data == 64'h0000_0000_89AB_CDEF, "R6 immediate order", rd_data, 64'h89AB_CDEF);
    rd_sel = 4'd4; #1;
    chk(rd_data == 64'h0000_0001_1357_9BDE, "R4 R5 reg form", rd_data, 64'h1_1357_9BDE);
    rd_sel = 4'd15; #1;
    chk(rd_data == 0, "R12 selector 15", rd_data, 0);

    // R7 wrap
    clear_rom();
    add_imm(8'd1, 7'd0, 32'hFFFF_FFFF);
    for (int i = 0; i < 33; i++) add_reg(8'd1, 7'd1, 8'd1);
    emit(8'h0E);
    run_prog("R7 wrap");
    rd_sel = 4'd1; #1;
    chk(rd_data == 64'hFFFF_FFFE_0000_0000, "R7 wrap value", rd_data, 64'hFFFF_FFFE_0000_0000);

    // R8 illegal encodings, then resume
    for (int t = 0; t < 4; t++) begin
      clear_rom();
      add_imm(8'd5, 7'd0, 32'd7);
      case (t)
        0: add_reg(8'h00, 7'd5, 8'd5);
        1: add_imm(8'h0F, 7'd5, 32'd1);
        2: add_imm(8'd6, 7'h0F, 32'd1);
        default: add_reg(8'd5, 7'd5, 8'h0F);
      endcase
      add_imm(8'd7, 7'd5, 32'd2);
      emit(8'h0E);
      run_prog("R8 illegal register");
      chk(mfault == 1, "R8 model expects fault", 64'(mfault), 1);
      rd_sel = 4'd5; #1;
      chk(rd_data == 64'd7, "R8 no write", rd_data, 7);
      model_run(mpc);
      pulse_start();
      run_until_halt("R11 resume after fault");
      check_regs("R11 resume after fault");
    end

    // R9 fetch errors at random addresses
    for (int t = 0; t < 6; t++) begin
      clear_rom();
      gen_prog(12, 0);
      err_addr = $urandom % wp;
      run_prog("R9 fetch error");
      chk(mpc == err_addr, "R9 model pc", 64'(mpc), 64'(err_addr));
      err_addr = -1;
    end

    // R11 resume after halt, and start colliding with halt bytes
    clear_rom();
    emit(8'h0E);
    gen_prog(10, 0);
    do_reset();
    model_run(0);
    run_until_halt("R3 halt at 0");
    chk(mem_addr == 1, "R3 pc after halt", 64'(mem_addr), 1);
    model_run(mpc);
    pulse_start();
    run_until_halt("R11 resume after halt");
    check_regs("R11 registers kept");

    hlt_start = 1;
    poke = 1;
    for (int t = 0; t < 8; t++) begin
      clear_rom();
      gen_prog(8, 0);
      run_prog("R11 start collision");
    end
    hlt_start = 0;
    poke = 0;

    // random programs, some with illegal encodings
    for (int t = 0; t < 30; t++) begin
      clear_rom();
      gen_prog(5 + $urandom % 20, t % 3 == 0);
      run_prog("R2 R7 random program");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'h5EED_1234));
endmodule